// File: doc/BRIEF.md
# Synchronous rectifier gate timing controller

This block times the two gate drives on the secondary side of a forward converter. One output switches the rectifier transistor, which conducts while the primary clock is high. The other switches the freewheeling transistor, which conducts while the clock is low. The block runs on a fast sampling clock and takes a clock input that has already been synchronized into that domain. It measures how many ticks the high and low phases of each period last. It then uses the previous period's lengths to predict where the current phase will end, and releases each gate a set number of ticks before that predicted edge. This keeps the two transistors from ever conducting together.

Each gate switches on a fixed number of ticks after the edge that starts its phase. The freewheeling lead is a base tick count times one, two or three, chosen by a two-bit code. A rectifier lead of a fixed tick count is subtracted from the predicted high length. An inhibit input limits the freewheeling pulse to a minimum conduction window, so the converter can run in discontinuous mode. Both gates stay low until two complete periods have been measured. This holds after reset and after any phase that outlasts a timeout.

Top module: `srect_gate_ctrl`

## Requirements
- R1: The rectifier gate is high only inside a sampled high phase. It rises RECT_ON_DLY ticks after the tick in which the rising clock edge is first sampled.
- R2: The rectifier gate falls RECT_LEAD ticks before the end of the high phase, as predicted from the previous period's high length. That is, it falls at tick (previous high length − RECT_LEAD) counted from the rising edge sample.
- R3: The freewheeling gate is high only inside a sampled low phase. It rises FW_ON_DLY ticks after the falling edge sample and falls at tick (previous low length − freewheeling lead).
- R4: The freewheeling lead is FW_LEAD_BASE times a factor set by `ant_sel`: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 3.
- R5: While `inhibit` is high, the freewheeling gate is forced low from tick FW_ON_DLY+FW_MIN_ON of the low phase onward. It therefore conducts for at most FW_MIN_ON ticks.
- R6: If the predicted end tick of a gate (after lead and inhibit limit) is not later than its turn-on delay, that gate gives no pulse in the phase.
- R7: A clock edge that arrives before the predicted end forces the running gate low in that edge's tick. The two gates are never high in the same cycle.
- R8: After reset, both gates stay low until the third rising clock edge has been sampled, so that two full periods have been measured first.
- R9: A phase longer than TIMEOUT ticks discards the measurements. Both gates then stay low until the third rising edge after it.
- R10: While `rst` is high, both gates are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_in | input | 1 | Synchronized converter clock, high = rectifier phase |
| ant_sel | input | 2 | Freewheeling lead select code |
| inhibit | input | 1 | Limits the freewheeling pulse to its minimum conduction window |
| gate_rect | output | 1 | Rectifier gate drive, registered |
| gate_fw | output | 1 | Freewheeling gate drive, registered |

## Verification
Every result is tied to the tick in which a clock edge is first sampled. A gate rises at exactly its turn-on delay after that tick and falls at the predicted end tick or at the next edge tick, whichever comes first. The bench records the sampling tick of each edge it drives and pushes the rise and fall ticks it expects into a queue. It reads the registered gates half a clock period after each edge and compares every observed pulse to the queue entry with no slack, so a lead that is one tick off is reported. The warm-up, short-phase and timeout cases are checked by counting gate pulses over whole periods, and gate overlap is checked on every cycle.

// File: rtl/srg_pkg.sv
package srg_pkg;

  // Freewheeling lead select code
  typedef enum logic [1:0] {
    LEAD_X1  = 2'b00,
    LEAD_X2  = 2'b01,
    LEAD_X3  = 2'b10,
    LEAD_X3B = 2'b11
  } lead_sel_e;

  // Multiplier applied to the freewheeling lead base (R4)
  function automatic logic [1:0] lead_factor(input lead_sel_e s);
    case (s)
      LEAD_X1: lead_factor = 2'd1;
      LEAD_X2: lead_factor = 2'd2;
      default: lead_factor = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/srg_phase_meter.sv
// Edge detection, phase length measurement and warm-up qualification.
module srg_phase_meter #(
  parameter int CNT_W   = 12,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ck_in,
  output logic             phase_hi,
  output logic             edge_now,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len_hi,
  output logic [CNT_W-1:0] len_lo,
  output logic             valid
);

  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic             ck_d;
  logic [CNT_W-1:0] cnt_q, hi_q, lo_q;
  logic [1:0]       seen_q;   // rising edges since restart, saturating at 3
  logic             rise, fall;

  assign rise     = ck_in & ~ck_d;
  assign fall     = ~ck_in & ck_d;
  assign edge_now = rise | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_d   <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      seen_q <= 2'd0;
    end else begin
      ck_d <= ck_in;
      if (edge_now) begin
        cnt_q <= ONE_C;
        if (fall && seen_q != 2'd0) hi_q <= cnt_q;
        if (rise) begin
          if (seen_q != 2'd0) lo_q <= cnt_q;
          if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
        end
      end else if (cnt_q == TMO_C) begin
        seen_q <= 2'd0;           // phase overran: measurements stale (R9)
      end else begin
        cnt_q <= cnt_q + ONE_C;
      end
    end
  end

  assign phase_hi = ck_d;
  assign cnt      = cnt_q;
  assign len_hi   = hi_q;
  assign len_lo   = lo_q;
  assign valid    = (seen_q == 2'd3);

endmodule

// File: rtl/srg_gate_window.sv
// One gate: on from ON_DLY to (predicted length - lead), optionally capped.
module srg_gate_window #(
  parameter int CNT_W     = 12,
  parameter int ON_DLY    = 2,
  parameter int CAP_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             edge_now,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] pred,
  input  logic [CNT_W-1:0] lead,
  input  logic             cap_req,
  output logic             gate
);

  localparam logic [CNT_W-1:0] ON_C  = CNT_W'(ON_DLY);
  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(ON_DLY + CAP_TICKS);

  logic [CNT_W-1:0] end_raw, end_eff;
  logic             worth, gate_nx;

  always_comb begin
    end_raw = (pred > lead) ? (pred - lead) : '0;
    end_eff = (cap_req && end_raw > CAP_C) ? CAP_C : end_raw;
    worth   = (end_eff > ON_C);                      // R6
    gate_nx = enable & ~edge_now & worth &
              (cnt >= ON_C) & (cnt < end_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= gate_nx;
  end

endmodule

// File: rtl/srect_gate_ctrl.sv
module srect_gate_ctrl
  import srg_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int TIMEOUT      = 1000,
  parameter int RECT_ON_DLY  = 4,
  parameter int FW_ON_DLY    = 2,
  parameter int RECT_LEAD    = 1,
  parameter int FW_LEAD_BASE = 3,
  parameter int FW_MIN_ON    = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ck_in,
  input  logic [1:0] ant_sel,
  input  logic       inhibit,
  output logic       gate_rect,
  output logic       gate_fw
);

  localparam logic [CNT_W-1:0] RLEAD_C = CNT_W'(RECT_LEAD);
  localparam logic [CNT_W-1:0] FBASE_C = CNT_W'(FW_LEAD_BASE);

  logic             phase_hi, edge_now, valid;
  logic [CNT_W-1:0] cnt, len_hi, len_lo, lead_fw;

  srg_phase_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst(rst), .ck_in(ck_in),
    .phase_hi(phase_hi), .edge_now(edge_now), .cnt(cnt),
    .len_hi(len_hi), .len_lo(len_lo), .valid(valid)
  );

  always_comb lead_fw = FBASE_C * CNT_W'(lead_factor(lead_sel_e'(ant_sel)));

  srg_gate_window #(.CNT_W(CNT_W), .ON_DLY(RECT_ON_DLY), .CAP_TICKS(0)) u_rect (
    .clk(clk), .rst(rst), .enable(valid & phase_hi), .edge_now(edge_now),
    .cnt(cnt), .pred(len_hi), .lead(RLEAD_C), .cap_req(1'b0), .gate(gate_rect)
  );

  srg_gate_window #(.CNT_W(CNT_W), .ON_DLY(FW_ON_DLY), .CAP_TICKS(FW_MIN_ON)) u_fw (
    .clk(clk), .rst(rst), .enable(valid & ~phase_hi), .edge_now(edge_now),
    .cnt(cnt), .pred(len_lo), .lead(lead_fw), .cap_req(inhibit), .gate(gate_fw)
  );

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int MIN_ON = 10
) (
  input logic clk,
  input logic rst,
  input logic ck_in,
  input logic inhibit,
  input logic gate_rect,
  input logic gate_fw
);

  logic [15:0] run_q;   // consecutive cycles gate_fw has been sampled high
  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (!gate_fw) run_q <= '0;
    else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
  end

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(gate_rect && gate_fw));

  a_r1_rect_in_high: assert property (@(posedge clk) disable iff (rst)
    gate_rect |-> $past(ck_in));

  a_r3_fw_in_low: assert property (@(posedge clk) disable iff (rst)
    gate_fw |-> !$past(ck_in));

  a_r7_edge_clears: assert property (@(posedge clk) disable iff (rst)
    (ck_in != $past(ck_in)) |=> (!gate_rect && !gate_fw));

  a_r5_inhibit_cap: assert property (@(posedge clk) disable iff (rst)
    (gate_fw && $past(inhibit)) |-> (run_q < 16'(MIN_ON)));

  a_r10_reset_low: assert property (@(posedge clk)
    rst |=> (!gate_rect && !gate_fw));

endmodule

bind srect_gate_ctrl srg_checker #(.MIN_ON(FW_MIN_ON)) u_srg_chk (
  .clk(clk), .rst(rst), .ck_in(ck_in), .inhibit(inhibit),
  .gate_rect(gate_rect), .gate_fw(gate_fw)
);

// File: tb/srect_gate_ctrl_test.sv
module srect_gate_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO   = 1000;
  localparam int D1    = 4;
  localparam int D2    = 2;
  localparam int A1    = 1;
  localparam int ABASE = 3;
  localparam int MINON = 10;

  logic clk = 1'b0, rst = 1'b1, ck_in = 1'b0, inhibit = 1'b0;
  logic [1:0] ant_sel = 2'b00;
  logic gate_rect, gate_fw;

  srect_gate_ctrl #(.CNT_W(12), .TIMEOUT(TMO), .RECT_ON_DLY(D1), .FW_ON_DLY(D2),
                    .RECT_LEAD(A1), .FW_LEAD_BASE(ABASE), .FW_MIN_ON(MINON)) uut (
    .clk(clk), .rst(rst), .ck_in(ck_in), .ant_sel(ant_sel), .inhibit(inhibit),
    .gate_rect(gate_rect), .gate_fw(gate_fw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tick = 0;
  always @(posedge clk) tick <= tick + 1;

  int n_checks = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  typedef struct { int t_on; int t_off; string tag; } pulse_t;
  pulse_t q_rect[$], q_fw[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic score(ref pulse_t q[$], input int t_on, input int t_off,
                       input string on_tag);
    pulse_t it;
    if (q.size() == 0) begin
      check(1'b0, "R6", "unexpected pulse starting at tick", t_on, -1);
    end else begin
      it = q.pop_front();
      check(t_on == it.t_on, on_tag, "turn-on tick", t_on, it.t_on);
      check(t_off == it.t_off, it.tag, "turn-off tick", t_off, it.t_off);
    end
  endtask

  // Monitor: read registered gates half a period after each edge
  int  r_on = 0, f_on = 0;
  logic pr = 1'b0, pf = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      check(!(gate_rect && gate_fw), "R7", "both gates high",
            int'(gate_rect) + int'(gate_fw), 1);
      if (gate_rect && !pr) begin r_on = tick; pulses++; end
      if (!gate_rect && pr) score(q_rect, r_on, tick, "R1");
      if (gate_fw && !pf) begin f_on = tick; pulses++; end
      if (!gate_fw && pf) score(q_fw, f_on, tick, "R3");
      pr = gate_rect;
      pf = gate_fw;
    end
  end

  // Reference model state, from the requirements
  int rises = 0, prev_h = 0, prev_l = 0;

  function automatic int factor(logic [1:0] s);   // R4 code table
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 2;
    return 3;
  endfunction

  task automatic run_period(int h, int l, bit inh, logic [1:0] sel);
    int t0, e, off;
    bit v;
    // high phase
    @(negedge clk);
    t0 = tick + 1; ck_in = 1'b1; inhibit = inh; ant_sel = sel;
    rises = (rises < 3) ? rises + 1 : 3;
    v = (rises >= 3);
    e = prev_h - A1;
    if (v && e > D1) begin
      off = (e < h) ? e : h;
      if (off > D1) q_rect.push_back('{t0 + D1, t0 + off, (e < h) ? "R2" : "R7"});
    end
    repeat (h - 1) @(negedge clk);
    // low phase
    @(negedge clk);
    t0 = tick + 1; ck_in = 1'b0;
    e = prev_l - ABASE * factor(sel);
    if (inh && e > D2 + MINON) e = D2 + MINON;
    if (v && e > D2) begin
      off = (e < l) ? e : l;
      if (off > D2)
        q_fw.push_back('{t0 + D2, t0 + off,
                         (e >= l) ? "R7" : inh ? "R5" : (sel != 2'b00) ? "R4" : "R3"});
    end
    repeat (l - 1) @(negedge clk);
    prev_h = h;
    prev_l = l;
    if (l > TMO) rises = 0;   // R9 timeout model
  endtask

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    check(!gate_rect && !gate_fw, "R10", "gates during reset",
          int'(gate_rect) + int'(gate_fw), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R8: two warm-up periods give no pulses
    run_period(40, 40, 1'b0, 2'b00);
    run_period(40, 40, 1'b0, 2'b00);
    check(pulses == 0, "R8", "pulses during warm-up", pulses, 0);

    // steady operation, each lead setting (R2, R3, R4)
    run_period(40, 40, 1'b0, 2'b00);
    run_period(40, 40, 1'b0, 2'b01);
    run_period(40, 40, 1'b0, 2'b10);
    run_period(40, 40, 1'b0, 2'b11);

    // duty change: early edge cuts the rectifier pulse (R7), then re-predicts
    run_period(30, 60, 1'b0, 2'b00);
    run_period(30, 60, 1'b0, 2'b01);
    run_period(40, 40, 1'b0, 2'b00);

    // inhibit limits freewheeling conduction (R5)
    run_period(40, 40, 1'b1, 2'b10);
    run_period(40, 40, 1'b1, 2'b00);
    run_period(40, 40, 1'b0, 2'b00);

    // very short phases: windows collapse (R6)
    run_period(5, 5, 1'b0, 2'b00);
    p0 = pulses;
    run_period(5, 5, 1'b0, 2'b00);
    run_period(40, 40, 1'b0, 2'b00);
    check(pulses == p0, "R6", "pulses with collapsed window", pulses - p0, 0);
    run_period(40, 40, 1'b0, 2'b00);

    // timeout then re-qualification (R9)
    run_period(40, 2500, 1'b0, 2'b00);
    p0 = pulses;
    run_period(40, 40, 1'b0, 2'b00);
    run_period(40, 40, 1'b0, 2'b00);
    check(pulses == p0, "R9", "pulses after timeout", pulses - p0, 0);
    run_period(40, 40, 1'b0, 2'b01);
    run_period(40, 40, 1'b0, 2'b00);

    repeat (10) @(negedge clk);
    check(q_rect.size() == 0, "R2", "missing rectifier pulses", q_rect.size(), 0);
    check(q_fw.size() == 0, "R3", "missing freewheeling pulses", q_fw.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", tick, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule